// File: doc/BRIEF.md
# Copy-Protection Pulse Persistence Detector

This block watches incoming video for two parts of an analogue copy-protection scheme: bursts of surplus sync pulses that fall away from the normal sync position, and colour-stripe bursts flagged by the chroma path. Each field is judged on its own. A field counts as carrying surplus sync when it holds at least a programmed number of off-position sync strobes. A field counts as carrying stripes when the chroma path raised its stripe flag at any point during that field.

A status bit for each component goes high only after a programmed run of consecutive qualifying fields. It goes low again only after a run of the same length of consecutive non-qualifying fields. An 8-bit control register gives each component its own enable, the surplus-pulse threshold, and the field-run length. While stripe status is confirmed and stripe detection is enabled, the block raises a stripe-bypass output for the downstream chroma path. The analogue detection of the stripes themselves happens elsewhere.

Top module: `cp_persist_det`

## Requirements
- R1: After reset, both status outputs and the bypass output are 0. The control register holds 0x26, so both components are disabled and remain at 0 whatever the input activity.
- R2: When cfg_wr is high at a rising edge, the control register captures cfg_din. Its fields are: bit 7 = stripe enable, bit 6 = surplus-sync enable, bits 5:3 = surplus-pulse threshold T, bits 2:0 = field code C.
- R3: A surplus pulse is a cycle with sync_pulse high and sync_expected low. Pulses with sync_expected high are never counted.
- R4: A field ends at each field_start strobe. That field qualifies for surplus sync when its surplus pulse count is at least T. A surplus pulse in the same cycle as field_start belongs to the field that begins there.
- R5: A field qualifies for stripes when stripe_seen was high in at least one cycle of that field.
- R6: A status bit rises at the field_start that ends the N-th consecutive qualifying field, where N = C + 2. It changes at no other time while its component is enabled.
- R7: A set status bit falls at the field_start that ends the N-th consecutive non-qualifying field. Any qualifying field in between restarts that run.
- R8: While bit 6 is 0, the surplus-sync counters and pseudo_sync_det are held at 0. While bit 7 is 0, the stripe counters and stripe_det are held at 0. When an enable returns to 1, counting starts from zero.
- R9: stripe_bypass equals (stripe enable AND stripe_det) delayed by one clock cycle.
- R10: The two components qualify and persist independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_din | input | 8 | Control register write data |
| field_start | input | 1 | One-cycle strobe marking a new field |
| sync_pulse | input | 1 | One-cycle strobe per detected sync pulse |
| sync_expected | input | 1 | High when the current sync pulse is at the expected position |
| stripe_seen | input | 1 | Colour-stripe indication from the chroma path |
| pseudo_sync_det | output | 1 | Surplus-sync component confirmed |
| stripe_det | output | 1 | Colour-stripe component confirmed |
| stripe_bypass | output | 1 | Stripe bypass request to the chroma path |

## Verification
The bench places a surplus pulse in the same cycle as field_start. A design that assigns that pulse to the closing field would confirm one field early or one field late. It runs fields whose pulse count sits exactly at, one below and above the threshold, and it mixes expected-position pulses into them. A wrong comparison or counting expected pulses would set the status on the wrong field. It breaks qualifying runs and non-qualifying runs with a single opposite field, which a design without run restart would not notice. It also drops an enable bit while the status is set and then re-enables, so that leftover counts, or a status that survives the disable, become visible.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int THR_W    = 3;                 // surplus-pulse threshold field width
  localparam int FCODE_W  = 3;                 // field-run code width
  localparam int FIELD_BIAS = 2;               // run length = code + bias
  localparam int COMP_N   = 2;
  localparam int COMP_PSEUDO = 0;
  localparam int COMP_STRIPE = 1;
  localparam int ACC_W    = THR_W + 1;         // per-field event counter width
  localparam int RUN_W    = FCODE_W + 1;       // consecutive-field counter width

  typedef struct packed {
    logic               stripe_en;
    logic               pseudo_en;
    logic [THR_W-1:0]   pulse_thr;
    logic [FCODE_W-1:0] field_code;
  } cfg_t;

  function automatic logic [RUN_W-1:0] run_need(input logic [FCODE_W-1:0] code);
    return RUN_W'(code) + RUN_W'(FIELD_BIAS);
  endfunction
endpackage

// File: rtl/cpd_cfg_reg.sv
module cpd_cfg_reg
  import cpd_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = 8'h26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] din_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= cfg_t'(RESET_VAL);
    else if (wr_i) cfg_q <= cfg_t'(din_i);
  end

  assign cfg_o = cfg_q;

  // R2: a write is visible on the next cycle
  p_write_capture_r2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (cfg_o == cfg_t'($past(din_i))));
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(cfg_o));
endmodule

// File: rtl/cpd_field_acc.sv
module cpd_field_acc #(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             field_start_i,
  input  logic             event_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic             qual_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (field_start_i) begin
      // an event on the boundary cycle opens the new field's count
      cnt_q <= event_i ? ACC_W'(1) : '0;
    end else if (event_i && cnt_q != ACC_MAX) begin
      cnt_q <= cnt_q + ACC_W'(1);
    end
  end

  assign qual_o = (cnt_q >= thr_i);

  // R4: the counter saturates instead of wrapping
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && !field_start_i && cnt_q == ACC_MAX) |=> (cnt_q == ACC_MAX));
  // R4: a field boundary restarts the count at zero or one
  p_boundary_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && field_start_i) |=> (cnt_q <= ACC_W'(1)));
  // R8: disabled accumulator stays empty
  p_acc_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cpd_persist.sv
module cpd_persist #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             field_start_i,
  input  logic             qual_i,
  input  logic [RUN_W-1:0] need_i,
  output logic             status_o
);
  localparam int EXT_W = RUN_W + 1;

  logic [RUN_W-1:0] hit_q, miss_q;
  logic             status_q;
  logic [EXT_W-1:0] hit_inc, miss_inc;
  logic             hit_done, miss_done;

  always_comb begin
    hit_inc   = EXT_W'(hit_q)  + EXT_W'(1);
    miss_inc  = EXT_W'(miss_q) + EXT_W'(1);
    hit_done  = (hit_inc  >= EXT_W'(need_i));
    miss_done = (miss_inc >= EXT_W'(need_i));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      hit_q    <= '0;
      miss_q   <= '0;
      status_q <= 1'b0;
    end else if (field_start_i) begin
      if (qual_i) begin
        miss_q <= '0;
        hit_q  <= hit_done ? need_i : RUN_W'(hit_inc);
        if (hit_done) status_q <= 1'b1;
      end else begin
        hit_q  <= '0;
        miss_q <= miss_done ? need_i : RUN_W'(miss_inc);
        if (miss_done) status_q <= 1'b0;
      end
    end
  end

  assign status_o = status_q;

  // R6: status moves only on a field boundary
  p_hold_between_fields_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && !field_start_i) |=> $stable(status_o));
  // R6: status rises only after a qualifying field
  p_rise_on_qual_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o) |-> $past(qual_i && field_start_i));
  // R7: status falls only after a non-qualifying field or a disable
  p_fall_on_miss_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o) |-> $past(!en_i || (field_start_i && !qual_i)));
  // R7: the two runs never both hold a count
  p_runs_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !((hit_q != '0) && (miss_q != '0)));
  // R8: disabled component reads zero on the next cycle
  p_disabled_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !status_o);
endmodule

// File: rtl/cp_persist_det.sv
module cp_persist_det
  import cpd_pkg::*;
#(
  parameter logic [7:0] CFG_RESET = 8'h26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_din,
  input  logic       field_start,
  input  logic       sync_pulse,
  input  logic       sync_expected,
  input  logic       stripe_seen,
  output logic       pseudo_sync_det,
  output logic       stripe_det,
  output logic       stripe_bypass
);
  cfg_t             cfg;
  logic [RUN_W-1:0] need;
  logic             comp_en    [COMP_N];
  logic             comp_event [COMP_N];
  logic [ACC_W-1:0] comp_thr   [COMP_N];
  logic             comp_qual  [COMP_N];
  logic             comp_stat  [COMP_N];
  logic             bypass_q;

  cpd_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (cfg_wr),
    .din_i (cfg_din),
    .cfg_o (cfg)
  );

  assign need = run_need(cfg.field_code);

  always_comb begin
    comp_en[COMP_PSEUDO]    = cfg.pseudo_en;
    comp_event[COMP_PSEUDO] = sync_pulse && !sync_expected;
    comp_thr[COMP_PSEUDO]   = ACC_W'(cfg.pulse_thr);
    comp_en[COMP_STRIPE]    = cfg.stripe_en;
    comp_event[COMP_STRIPE] = stripe_seen;
    comp_thr[COMP_STRIPE]   = ACC_W'(1);
  end

  for (genvar c = 0; c < COMP_N; c++) begin : g_comp
    cpd_field_acc #(.ACC_W(ACC_W)) u_acc (
      .clk           (clk),
      .rst           (rst),
      .en_i          (comp_en[c]),
      .field_start_i (field_start),
      .event_i       (comp_event[c]),
      .thr_i         (comp_thr[c]),
      .qual_o        (comp_qual[c])
    );
    cpd_persist #(.RUN_W(RUN_W)) u_run (
      .clk           (clk),
      .rst           (rst),
      .en_i          (comp_en[c]),
      .field_start_i (field_start),
      .qual_i        (comp_qual[c]),
      .need_i        (need),
      .status_o      (comp_stat[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bypass_q <= 1'b0;
    else     bypass_q <= cfg.stripe_en && comp_stat[COMP_STRIPE];
  end

  assign pseudo_sync_det = comp_stat[COMP_PSEUDO];
  assign stripe_det      = comp_stat[COMP_STRIPE];
  assign stripe_bypass   = bypass_q;

  // R9: bypass only follows a confirmed stripe status
  p_bypass_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stripe_bypass) |-> $past(stripe_det && cfg.stripe_en));
  p_bypass_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (stripe_det && cfg.stripe_en) |=> stripe_bypass);
  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pseudo_sync_det && !stripe_det && !stripe_bypass));
endmodule

// File: tb/cp_persist_det_tb.sv
module cp_persist_det_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_din = 8'h00;
  logic       field_start = 1'b0;
  logic       sync_pulse = 1'b0;
  logic       sync_expected = 1'b0;
  logic       stripe_seen = 1'b0;
  logic       pseudo_sync_det, stripe_det, stripe_bypass;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cp_persist_det u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .field_start(field_start), .sync_pulse(sync_pulse),
    .sync_expected(sync_expected), .stripe_seen(stripe_seen),
    .pseudo_sync_det(pseudo_sync_det), .stripe_det(stripe_det),
    .stripe_bypass(stripe_bypass)
  );

  // {surplus[10:7], expected[6:3], stripe[2], exp_pseudo[1], exp_stripe[0]}
  // control 0xD9: both enables, threshold 3, run length 3
  localparam int NV = 11;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {4'd3, 4'd0, 1'b1, 1'b0, 1'b0},
    {4'd3, 4'd0, 1'b0, 1'b0, 1'b0},
    {4'd4, 4'd0, 1'b1, 1'b1, 1'b0},
    {4'd2, 4'd0, 1'b1, 1'b1, 1'b0},
    {4'd5, 4'd5, 1'b1, 1'b1, 1'b1},
    {4'd0, 4'd8, 1'b0, 1'b1, 1'b1},
    {4'd0, 4'd0, 1'b0, 1'b1, 1'b1},
    {4'd0, 4'd0, 1'b1, 1'b0, 1'b1},
    {4'd7, 4'd0, 1'b0, 1'b0, 1'b1},
    {4'd0, 4'd0, 1'b0, 1'b0, 1'b1},
    {4'd0, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_din = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic run_field(input int nx, input int ne, input bit st, input bit coinc);
    for (int i = 0; i < nx; i++) begin
      @(negedge clk); sync_pulse = 1'b1; sync_expected = 1'b0;
      @(negedge clk); sync_pulse = 1'b0;
    end
    for (int i = 0; i < ne; i++) begin
      @(negedge clk); sync_pulse = 1'b1; sync_expected = 1'b1;
      @(negedge clk); sync_pulse = 1'b0; sync_expected = 1'b0;
    end
    if (st) begin
      @(negedge clk); stripe_seen = 1'b1;
      repeat (3) @(negedge clk);
      stripe_seen = 1'b0;
    end
    @(negedge clk); field_start = 1'b1;
    if (coinc) begin sync_pulse = 1'b1; sync_expected = 1'b0; end
    @(negedge clk); field_start = 1'b0; sync_pulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pseudo after reset", pseudo_sync_det, 1'b0);
    check("R1 stripe after reset", stripe_det, 1'b0);
    check("R1 bypass after reset", stripe_bypass, 1'b0);

    // default control keeps both components disabled
    for (int f = 0; f < 4; f++) run_field(7, 0, 1'b1, 1'b0);
    check("R1 R8 pseudo stays off at default", pseudo_sync_det, 1'b0);
    check("R1 R8 stripe stays off at default", stripe_det, 1'b0);
    check("R1 R9 bypass stays off at default", stripe_bypass, 1'b0);

    // R2 R3 R4 R5 R6 R7 R9 R10: vector walk
    write_cfg(8'hD9);
    run_field(0, 0, 1'b0, 1'b0);
    for (int v = 0; v < NV; v++) begin
      run_field(int'(VEC[v][10:7]), int'(VEC[v][6:3]), VEC[v][2], 1'b0);
      check($sformatf("R4 R6 R7 pseudo vec %0d", v), pseudo_sync_det, VEC[v][1]);
      check($sformatf("R5 R6 R7 R10 stripe vec %0d", v), stripe_det, VEC[v][0]);
      check($sformatf("R9 bypass vec %0d", v), stripe_bypass, VEC[v][0]);
    end

    // R4: a pulse on the boundary cycle opens the next field (threshold 2, run 2)
    write_cfg(8'h50);
    run_field(0, 0, 1'b0, 1'b0);
    run_field(1, 0, 1'b0, 1'b1);
    check("R4 boundary field A", pseudo_sync_det, 1'b0);
    run_field(1, 0, 1'b0, 1'b0);
    check("R4 boundary field B", pseudo_sync_det, 1'b0);
    run_field(2, 0, 1'b0, 1'b0);
    check("R4 boundary field C", pseudo_sync_det, 1'b1);
    check("R8 stripe off while bit7 clear", stripe_det, 1'b0);

    // R8: disable clears, re-enable restarts from zero
    write_cfg(8'h10);
    @(negedge clk);
    check("R8 pseudo cleared by disable", pseudo_sync_det, 1'b0);
    write_cfg(8'h50);
    run_field(2, 0, 1'b0, 1'b0);
    check("R8 restart needs full run", pseudo_sync_det, 1'b0);
    run_field(2, 0, 1'b0, 1'b0);
    check("R8 R6 set after full run", pseudo_sync_det, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule